// File: doc/BRIEF.md
# UART Transmit Flow-Control Gate

This block is placed between a UART transmit shifter and the serial pin. It watches every character the receiver delivers. Under in-band software flow control, a received pause character stops transmission and a received resume character restarts it. When the resume-on-any option is set, any received character other than the pause character also restarts a paused transmitter. Pause and resume characters are removed from the receive path while software flow control is enabled. All other characters are passed on to the receive FIFO as one-cycle push strobes.

The gate also applies a forced break on the line. While break is requested, the serial output is held at the space (low) level, whatever the shifter drives. Break ends only when software clears the request; there is no timer. The shifter samples the transmit-permit output only between characters, so a character already in progress always finishes before a pause takes effect. The pause and resume character values are programmable inputs.

Top module: `uart_tx_flow_gate`

## Requirements
- R1: Out of reset, `tx_permit_o` is 1, `fifo_push_o` is 0, `fifo_data_o` is 0 and `line_o` is 1 (mark).
- R2: When a character equal to `xoff_char_i` is received while `sw_flow_en_i` is 1, `tx_permit_o` is 0 from the next cycle on.
- R3: When a character equal to `xon_char_i` is received while paused, `tx_permit_o` returns to 1 on the next cycle. If the same character arrives while not paused, it changes nothing and `tx_permit_o` stays 1.
- R4: A pause character received while already paused leaves the block paused, even when `xon_any_en_i` is 1.
- R5: With `xon_any_en_i` at 0, an ordinary character (neither pause nor resume value) received while paused does not restore `tx_permit_o`.
- R6: With `xon_any_en_i` at 1, an ordinary character received while paused sets `tx_permit_o` to 1 on the next cycle. The same character is also pushed to the FIFO in that cycle.
- R7: A received character is presented one cycle after its `rx_valid_i` strobe as a single-cycle `fifo_push_o` with `fifo_data_o` equal to the byte. The exception is a character equal to the pause or resume value while `sw_flow_en_i` is 1: it produces no push.
- R8: While `sw_flow_en_i` is 0, `tx_permit_o` is 1 in the same cycle, any pause state is cleared, and every received character, including the pause and resume values, is pushed.
- R9: While `break_en_i` is 1, `line_o` is 0 from the next cycle on, whatever `tx_serial_i` is, for as long as break stays set. It is released one cycle after `break_en_i` falls.
- R10: Without break, `line_o` follows `tx_serial_i` with one cycle of latency.
- R11: If the pause and resume values are equal, a matching character is treated as the pause character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Strobe: received character valid |
| rx_data_i | input | 8 | Received character |
| xon_char_i | input | 8 | Resume character value |
| xoff_char_i | input | 8 | Pause character value |
| sw_flow_en_i | input | 1 | Software flow control enable |
| xon_any_en_i | input | 1 | Resume on any received character |
| break_en_i | input | 1 | Force line to space |
| tx_serial_i | input | 1 | Raw serial bit from the shifter |
| tx_permit_o | output | 1 | Shifter may start a new character |
| fifo_push_o | output | 1 | Push strobe toward the receive FIFO |
| fifo_data_o | output | 8 | Byte pushed toward the receive FIFO |
| line_o | output | 1 | Final serial line |

## Verification
With resume-on-any enabled, one ordinary character can do two things in the same cycle. It lifts the pause on the transmitter, and it is delivered to the FIFO. The bench pauses the block with the pause character and then sends an ordinary byte with the option on. One cycle later it checks that `tx_permit_o` has risen and that `fifo_push_o` carries that byte. A break request is also held during a pause-character reception, to show that the line override and the flow decision do not interact.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [1:0] {
    CLS_DATA = 2'd0,
    CLS_XON  = 2'd1,
    CLS_XOFF = 2'd2
  } rx_class_e;
endpackage

// File: rtl/uart_fc_classify.sv
module uart_fc_classify
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] xon_char_i,
  input  logic [DATA_W-1:0] xoff_char_i,
  output rx_class_e         class_o
);
  // pause value wins when both programmable values collide
  always_comb begin
    if (data_i == xoff_char_i)     class_o = CLS_XOFF;
    else if (data_i == xon_char_i) class_o = CLS_XON;
    else                           class_o = CLS_DATA;
  end
endmodule

// File: rtl/uart_fc_pause.sv
module uart_fc_pause
  import uart_fc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rx_valid_i,
  input  rx_class_e rx_class_i,
  input  logic      sw_flow_en_i,
  input  logic      xon_any_en_i,
  output logic      tx_permit_o
);
  logic paused_q, paused_d;

  always_comb begin
    paused_d = paused_q;
    if (!sw_flow_en_i) begin
      paused_d = 1'b0;
    end else if (rx_valid_i) begin
      unique case (rx_class_i)
        CLS_XOFF: paused_d = 1'b1;
        CLS_XON:  paused_d = 1'b0;
        default:  if (xon_any_en_i) paused_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) paused_q <= 1'b0;
    else         paused_q <= paused_d;
  end

  assign tx_permit_o = !(paused_q && sw_flow_en_i);

  AST_XOFF_PAUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_flow_en_i && rx_valid_i && rx_class_i == CLS_XOFF) |=> paused_q); // R2
  AST_XON_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_flow_en_i && rx_valid_i && rx_class_i == CLS_XON) |=> !paused_q); // R3
  AST_ANY_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_flow_en_i && xon_any_en_i && rx_valid_i && rx_class_i == CLS_DATA) |=> !paused_q); // R6
  AST_DATA_HOLDS_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_q && sw_flow_en_i && !xon_any_en_i && rx_valid_i && rx_class_i == CLS_DATA)
      |=> paused_q); // R5
  AST_FLOW_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_flow_en_i |=> !paused_q); // R8
endmodule

// File: rtl/uart_fc_rxfilter.sv
module uart_fc_rxfilter
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  rx_class_e         rx_class_i,
  input  logic              sw_flow_en_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o
);
  logic keep;
  assign keep = rx_valid_i && (!sw_flow_en_i || rx_class_i == CLS_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o <= 1'b0;
      data_o <= '0;
    end else begin
      push_o <= keep;
      if (keep) data_o <= rx_data_i;
    end
  end

  AST_FLOW_CHAR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && sw_flow_en_i && rx_class_i != CLS_DATA) |=> !push_o); // R7
  AST_DATA_PUSHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !sw_flow_en_i) |=> (push_o && data_o == $past(rx_data_i))); // R8
  AST_NO_SPURIOUS_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !push_o); // R7
endmodule

// File: rtl/uart_fc_line.sv
module uart_fc_line #(
  parameter bit LINE_REG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic break_en_i,
  input  logic tx_serial_i,
  output logic line_o
);
  logic line_d;
  assign line_d = break_en_i ? 1'b0 : tx_serial_i;

  generate
    if (LINE_REG) begin : g_reg
      logic line_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= 1'b1;
        else         line_q <= line_d;
      end
      assign line_o = line_q;

      AST_BREAK_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_en_i |=> !line_o); // R9
      AST_LINE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !break_en_i |=> (line_o == $past(tx_serial_i))); // R10
    end else begin : g_comb
      assign line_o = line_d;
    end
  endgenerate
endmodule

// File: rtl/uart_tx_flow_gate.sv
module uart_tx_flow_gate
  import uart_fc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit LINE_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [DATA_W-1:0] xon_char_i,
  input  logic [DATA_W-1:0] xoff_char_i,
  input  logic              sw_flow_en_i,
  input  logic              xon_any_en_i,
  input  logic              break_en_i,
  input  logic              tx_serial_i,
  output logic              tx_permit_o,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              line_o
);
  rx_class_e rx_class;

  uart_fc_classify #(.DATA_W(DATA_W)) u_classify (
    .data_i      (rx_data_i),
    .xon_char_i  (xon_char_i),
    .xoff_char_i (xoff_char_i),
    .class_o     (rx_class)
  );

  uart_fc_pause u_pause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_class_i   (rx_class),
    .sw_flow_en_i (sw_flow_en_i),
    .xon_any_en_i (xon_any_en_i),
    .tx_permit_o  (tx_permit_o)
  );

  uart_fc_rxfilter #(.DATA_W(DATA_W)) u_rxfilter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_class_i   (rx_class),
    .sw_flow_en_i (sw_flow_en_i),
    .push_o       (fifo_push_o),
    .data_o       (fifo_data_o)
  );

  uart_fc_line #(.LINE_REG(LINE_REG)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .break_en_i  (break_en_i),
    .tx_serial_i (tx_serial_i),
    .line_o      (line_o)
  );

  AST_PERMIT_WITHOUT_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_flow_en_i |-> tx_permit_o); // R8
  AST_XOFF_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_flow_en_i && rx_valid_i && rx_data_i == xoff_char_i && xoff_char_i == xon_char_i
     && sw_flow_en_i) |=> (!tx_permit_o || !sw_flow_en_i)); // R11
endmodule

// File: tb/uart_tx_flow_gate_test.sv
module uart_tx_flow_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] xon_c = 8'h11;
  logic [7:0] xoff_c = 8'h13;
  logic flow_en = 1'b0, xon_any = 1'b0, brk = 1'b0, tx_ser = 1'b1;
  logic permit, push, line;
  logic [7:0] pdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_tx_flow_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .xon_char_i(xon_c), .xoff_char_i(xoff_c), .sw_flow_en_i(flow_en),
    .xon_any_en_i(xon_any), .break_en_i(brk), .tx_serial_i(tx_ser),
    .tx_permit_o(permit), .fifo_push_o(push), .fifo_data_o(pdata), .line_o(line)
  );

  typedef struct packed {
    logic       v;
    logic [7:0] d;
    logic       fe;
    logic       xa;
    logic       bk;
    logic       tx;
    logic       e_perm;
    logic       e_push;
    logic [7:0] e_data;
    logic       e_line;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h41, 1'b1, 4'd7},  // R7 data push
    '{1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 pause
    '{1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 repeat pause
    '{1'b1, 8'h42, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h42, 1'b1, 4'd5},  // R5 no resume
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 line follows
    '{1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 resume
    '{1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 resume when running
    '{1'b1, 8'h13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},
    '{1'b1, 8'h55, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 4'd6},  // R6 any resumes + push
    '{1'b1, 8'h13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 permit
    '{1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h13, 1'b1, 4'd8},  // R8 pass xoff
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1, 4'd8},  // R8 pass xon
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 cleared
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 break
    '{1'b1, 8'h13, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd9}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, outputs then sampled at the following negedge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "permit", {7'd0, permit}, 8'd1);
    chk("R1", "push", {7'd0, push}, 8'd0);
    chk("R1", "data", pdata, 8'd0);
    chk("R1", "line", {7'd0, line}, 8'd1);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      rx_valid = VEC[i].v; rx_data = VEC[i].d; flow_en = VEC[i].fe;
      xon_any = VEC[i].xa; brk = VEC[i].bk; tx_ser = VEC[i].tx;
      step();
      tag = $sformatf("R%0d", VEC[i].req);
      chk(tag, $sformatf("permit v%0d", i), {7'd0, permit}, {7'd0, VEC[i].e_perm});
      chk(tag, $sformatf("push v%0d", i), {7'd0, push}, {7'd0, VEC[i].e_push});
      if (VEC[i].e_push) chk(tag, $sformatf("data v%0d", i), pdata, VEC[i].e_data);
      chk(tag, $sformatf("line v%0d", i), {7'd0, line}, {7'd0, VEC[i].e_line});
    end
    rx_valid = 1'b0;
    step();

    // R9 break persists with no timeout while the shifter toggles
    brk = 1'b1;
    step();
    for (int k = 0; k < 500; k++) begin
      tx_ser = k[0];
      step();
      if (k % 100 == 0) chk("R9", "line held", {7'd0, line}, 8'd0);
      else if (line !== 1'b0) chk("R9", "line held", {7'd0, line}, 8'd0);
    end
    brk = 1'b0; tx_ser = 1'b1;
    step();
    chk("R9", "line released", {7'd0, line}, 8'd1);

    // R11 equal values act as pause
    flow_en = 1'b1; xon_any = 1'b0;
    xon_c = 8'h20; xoff_c = 8'h20;
    rx_valid = 1'b1; rx_data = 8'h20;
    step();
    rx_valid = 1'b0;
    chk("R11", "permit", {7'd0, permit}, 8'd0);
    chk("R11", "push", {7'd0, push}, 8'd0);
    step();
    chk("R11", "permit hold", {7'd0, permit}, 8'd0);

    // R1 reset while paused
    rst_n = 1'b0;
    step();
    chk("R1", "permit after reset", {7'd0, permit}, 8'd1);
    rst_n = 1'b1;
    step();
    chk("R1", "permit stays", {7'd0, permit}, 8'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule